// File: doc/BRIEF.md
# Flash Toggle-Bit Status Poller

This host-side controller works out how an embedded program or erase operation inside a parallel NOR flash has ended. It does this by reading the flash status byte again and again. A start pulse latches two things: the address to poll and a mode bit. Reads then go out over a synchronous request/valid handshake. The controller judges the outcome by comparing pairs of reads and reports one of four results with a single-cycle done pulse.

In status mode, the toggling bit is compared across a pair of reads. If it has stopped, the operation is complete. If it is still moving, the timeout flag decides the next step:

- With the flag clear, polling continues with another pair of reads.
- With the flag set, one more pair is read, so that the race between the two bits is resolved before an error is declared.

In suspend-test mode, one pair of reads is taken and only the suspend bit is compared. The caller picks the polled address: for a program operation it is the program address, and for a sector erase it is any address inside a sector being erased.

The state machine has seven states:

| State | Role |
|---|---|
| ST_IDLE | Waits for start. |
| ST_RD0 | First read of a pair. |
| ST_RD1 | Second read of a pair. |
| ST_JUDGE | Decides after a pair. |
| ST_RC0 | First read of the recheck pair. |
| ST_RC1 | Second read of the recheck pair. |
| ST_RJUDGE | Decides after the recheck. |

Its transitions are:

- ST_IDLE to ST_RD0 on start.
- ST_RD0 to ST_RD1, and ST_RD1 to ST_JUDGE, each on a transfer.
- ST_JUDGE to ST_IDLE when the result is final.
- ST_JUDGE to ST_RD0 on "toggling, flag clear".
- ST_JUDGE to ST_RC0 on "toggling, flag set".
- ST_RC0 to ST_RC1, and ST_RC1 to ST_RJUDGE, each on a transfer.
- ST_RJUDGE to ST_IDLE always.

Top module: `toggle_poller`

## Requirements
- R1: Reset state. After reset, busy, done and rd_req are 0 and result is 0.
- R2: Complete on first pair. In status mode (mode=0), if bit 6 of the status byte is equal in two consecutive reads, the result is complete (code 0) after exactly those two reads.
- R3: Keep polling. In status mode, if bit 6 differs between the two reads of a pair and bit 5 of the second read is 0, another pair of reads is issued and judged the same way.
- R4: Recheck resolves to complete. In status mode, if bit 6 differs and bit 5 of the second read is 1, exactly two more reads are made. If bit 6 is equal across those two, the result is complete (code 0).
- R5: Timeout error. If bit 6 still differs on that recheck pair, the result is exceeded-time error (code 1). The controller goes idle and issues no further reads.
- R6: Suspend test. In suspend-test mode (mode=1), exactly two reads are made. The result is code 2 (in erase suspend) if bit 2 differs between them, and code 3 (not suspended) otherwise. Bits 6 and 5 have no effect in this mode.
- R7: Address and mode latching. poll_addr and mode are sampled on the start cycle, and every read carries that latched address on rd_addr.
- R8: Done pulse and result hold. done is high for exactly one cycle, in the same cycle that busy falls. result changes only together with done.
- R9: Start while busy. A start pulse while busy is high is ignored: the running operation keeps its mode, address, read count and result.
- R10: Read handshake. A read transfers in a cycle where rd_req and rd_valid are both high. rd_req stays high from the start of a read until its transfer, whatever the response latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling, taken only when idle |
| mode | input | 1 | 0 = status path, 1 = suspend-test path |
| poll_addr | input | ADDR_W | Address to poll |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read address |
| rd_valid | input | 1 | Read data valid; a transfer when high with rd_req |
| rd_data | input | DATA_W | Status byte read from the flash |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| result | output | 2 | 0 complete, 1 timeout error, 2 suspended, 3 not suspended |

## Verification
The bench builds the poller with ADDR_W=12 and the default 8-bit data path with bit positions 6, 5 and 2. The narrow address keeps the two distinct poll addresses easy to tell apart in the busy-start test. A behavioural flash model plays scripted status bytes with a programmable response latency from one to several cycles. This reaches the cases where rd_req must be held across wait cycles, multi-pair polling, the race recheck, and both suspend outcomes, including suspend-test bytes whose bit 6 moves.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD0,
        ST_RD1,
        ST_JUDGE,
        ST_RC0,
        ST_RC1,
        ST_RJUDGE
    } state_t;

    typedef enum logic [1:0] {
        RES_COMPLETE  = 2'd0,
        RES_TIMEOUT   = 2'd1,
        RES_SUSPENDED = 2'd2,
        RES_ACTIVE    = 2'd3
    } res_t;

    // positions inside the captured status slice
    localparam int SL_BUSY = 2;
    localparam int SL_TMO  = 1;
    localparam int SL_SUSP = 0;
    localparam int SL_W    = 3;
endpackage

// File: rtl/tbp_snap.sv
module tbp_snap #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_first,
    input  logic         ld_second,
    input  logic [W-1:0] din,
    output logic [W-1:0] first,
    output logic [W-1:0] second
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first  <= '0;
            second <= '0;
        end else begin
            if (ld_first)  first  <= din;
            if (ld_second) second <= din;
        end
    end
endmodule

// File: rtl/tbp_judge.sv
module tbp_judge
    import tbp_pkg::*;
(
    input  logic [SL_W-1:0] first,
    input  logic [SL_W-1:0] second,
    output logic            busy_tog,
    output logic            susp_tog,
    output logic            tmo_flag
);
    always_comb begin
        busy_tog = first[SL_BUSY] ^ second[SL_BUSY];
        susp_tog = first[SL_SUSP] ^ second[SL_SUSP];
        tmo_flag = second[SL_TMO];
    end
endmodule

// File: rtl/toggle_poller.sv
module toggle_poller
    import tbp_pkg::*;
#(
    parameter int ADDR_W   = 21,
    parameter int DATA_W   = 8,
    parameter int BUSY_BIT = 6,
    parameter int TMO_BIT  = 5,
    parameter int SUSP_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode,
    input  logic [ADDR_W-1:0] poll_addr,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic [1:0]        result
);
    state_t state, state_nx;
    logic   mode_q;
    logic   xfer;
    logic   busy_tog, susp_tog, tmo_flag;
    logic   fin;
    res_t   code;
    logic [SL_W-1:0] slice, first, second;
    logic   unused_data;

    assign unused_data = ^rd_data;

    always_comb begin
        slice          = '0;
        slice[SL_BUSY] = rd_data[BUSY_BIT];
        slice[SL_TMO]  = rd_data[TMO_BIT];
        slice[SL_SUSP] = rd_data[SUSP_BIT];
    end

    assign rd_req = (state == ST_RD0) || (state == ST_RD1) ||
                    (state == ST_RC0) || (state == ST_RC1);
    assign xfer   = rd_req && rd_valid;
    assign busy   = (state != ST_IDLE);

    tbp_snap #(.W(SL_W)) u_snap (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_first  (xfer && (state == ST_RD0 || state == ST_RC0)),
        .ld_second (xfer && (state == ST_RD1 || state == ST_RC1)),
        .din       (slice),
        .first     (first),
        .second    (second)
    );

    tbp_judge u_judge (
        .first    (first),
        .second   (second),
        .busy_tog (busy_tog),
        .susp_tog (susp_tog),
        .tmo_flag (tmo_flag)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_RD0;
            ST_RD0:    if (xfer) state_nx = ST_RD1;
            ST_RD1:    if (xfer) state_nx = ST_JUDGE;
            ST_JUDGE: begin
                if (mode_q || !busy_tog) state_nx = ST_IDLE;
                else if (!tmo_flag)      state_nx = ST_RD0;
                else                     state_nx = ST_RC0;
            end
            ST_RC0:    if (xfer) state_nx = ST_RC1;
            ST_RC1:    if (xfer) state_nx = ST_RJUDGE;
            ST_RJUDGE: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register plus start-time captures
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            mode_q  <= 1'b0;
            rd_addr <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start) begin
                mode_q  <= mode;
                rd_addr <= poll_addr;
            end
        end
    end

    // outcome decode
    always_comb begin
        fin  = (state == ST_RJUDGE) ||
               ((state == ST_JUDGE) && (mode_q || !busy_tog));
        code = RES_COMPLETE;
        if (mode_q)
            code = susp_tog ? RES_SUSPENDED : RES_ACTIVE;
        else if (state == ST_RJUDGE && busy_tog)
            code = RES_TIMEOUT;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= RES_COMPLETE;
        end else begin
            done <= fin;
            if (fin) result <= code;
        end
    end
endmodule

// File: rtl/tbp_checker.sv
module tbp_checker #(
    parameter int ADDR_W = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              busy,
    input logic              done,
    input logic [1:0]        result
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                             // R8
    AST_DONE_WITH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy));                              // R8
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));                                  // R8
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_valid |=> rd_req);                             // R10
    AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> busy);                                            // R10
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(rd_addr));                   // R7
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done && result == 2'd1 |-> !rd_req);                         // R5
endmodule

bind toggle_poller tbp_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr),
    .busy     (busy),
    .done     (done),
    .result   (result)
);

// File: tb/sim_toggle_poller.sv
`timescale 1ns/1ps
module sim_toggle_poller;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          mode = 1'b0;
    logic [AW-1:0] poll_addr = '0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_valid = 1'b0;
    logic [7:0]    rd_data = 8'h00;
    logic          busy, done;
    logic [1:0]    result;

    int n_chk = 0;
    int n_fail = 0;

    // flash model state
    logic [7:0]    script [0:15];
    int            idx = 0;
    int            wcnt = 0;
    int            lat = 0;
    int            bad_addr = 0;
    int            req_drop = 0;
    logic [AW-1:0] exp_addr = '0;
    logic          prev_pend = 1'b0;

    always #2 clk = ~clk;

    toggle_poller #(.ADDR_W(AW), .DATA_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .poll_addr(poll_addr), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
        .done(done), .result(result)
    );

    // behavioural flash: answers each request after lat wait cycles
    always @(posedge clk) begin
        if (prev_pend && !rd_req) req_drop <= req_drop + 1;
        prev_pend <= rd_req && !rd_valid;
        if (rd_req && rd_valid) begin
            if (rd_addr != exp_addr) bad_addr <= bad_addr + 1;
            idx      <= idx + 1;
            rd_valid <= 1'b0;
            wcnt     <= 0;
        end else if (rd_req) begin
            if (wcnt >= lat) begin
                rd_valid <= 1'b1;
                rd_data  <= script[(idx > 15) ? 15 : idx];
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(input logic [63:0] v, input int n, input int latency);
        for (int i = 0; i < 16; i++)
            script[i] = (i < n) ? v[63-8*i -: 8] : v[63-8*(n-1) -: 8];
        idx = 0;
        bad_addr = 0;
        req_drop = 0;
        lat = latency;
    endtask

    task automatic pulse_start(input logic m, input logic [AW-1:0] a);
        @(negedge clk);
        start = 1'b1; mode = m; poll_addr = a;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        while (!done && t < 2000) begin
            @(negedge clk);
            t++;
        end
        if (!done) chk(1'b0, {req, " watchdog"}, t, 0);
    endtask

    task automatic run(input string req, input logic m, input logic [AW-1:0] a,
                       input int exp_res, input int exp_reads);
        exp_addr = a;
        pulse_start(m, a);
        wait_done(req);
        chk(result == exp_res[1:0], {req, " result"}, result, exp_res);
        chk(idx == exp_reads, {req, " reads"}, idx, exp_reads);
        chk(bad_addr == 0, {"R7 address ", req}, bad_addr, 0);
        chk(req_drop == 0, {"R10 req held ", req}, req_drop, 0);
        @(negedge clk);
        chk(!done, {"R8 done pulse ", req}, done, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy && !done && !rd_req && result == 2'd0, "R1 reset",
            {busy, done, rd_req, result}, 0);
    endtask

    task automatic t_complete_first();
        load({8'h40, 8'h40, 48'h0}, 2, 0);
        run("R2", 1'b0, 12'h123, 0, 2);
    endtask

    task automatic t_keep_polling();
        load({8'h40, 8'h00, 8'h40, 8'h00, 8'h00, 8'h00, 16'h0}, 6, 2);
        run("R3", 1'b0, 12'h0A5, 0, 6);
    endtask

    task automatic t_recheck_ok();
        load({8'h00, 8'h60, 8'h20, 8'h20, 32'h0}, 4, 1);
        run("R4", 1'b0, 12'h3C0, 0, 4);
    endtask

    task automatic t_timeout();
        int seen = 0;
        logic [1:0] r;
        load({8'h00, 8'h60, 8'h20, 8'h60, 32'h0}, 4, 0);
        run("R5", 1'b0, 12'h7FF, 1, 4);
        r = result;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (rd_req) seen++;
        end
        chk(seen == 0 && idx == 4, "R5 no reads after error", seen, 0);
        chk(result == r, "R8 result held", result, r);
    endtask

    task automatic t_suspend();
        load({8'h04, 8'h00, 48'h0}, 2, 1);
        run("R6 toggled", 1'b1, 12'h010, 2, 2);
        load({8'h44, 8'h04, 48'h0}, 2, 0);
        run("R6 steady", 1'b1, 12'h020, 3, 2);
        load({8'h60, 8'h24, 48'h0}, 2, 3);
        run("R6 bit5 ignored", 1'b1, 12'h030, 2, 2);
    endtask

    task automatic t_busy_start();
        load({8'h40, 8'h00, 8'h40, 8'h00, 8'h00, 8'h00, 16'h0}, 6, 2);
        exp_addr = 12'h555;
        pulse_start(1'b0, 12'h555);
        repeat (3) @(negedge clk);
        start = 1'b1; mode = 1'b1; poll_addr = 12'hAAA;
        @(negedge clk);
        start = 1'b0;
        wait_done("R9");
        chk(result == 2'd0, "R9 result", result, 0);
        chk(idx == 6, "R9 reads", idx, 6);
        chk(bad_addr == 0, "R9 address", bad_addr, 0);
        chk(req_drop == 0, "R10 req held R9", req_drop, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) script[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_complete_first();
        t_keep_polling();
        t_recheck_ok();
        t_timeout();
        t_suspend();
        t_busy_start();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule